// File: doc/BRIEF.md
# Byte/Word Data Lane Steering

This block sits between a host bus and a 16-bit memory array that the host may access either one byte at a time or one full word at a time. Two active-low card enables each own one external data lane: the low enable owns bits 7:0 and the high enable owns bits 15:8. Which enables are asserted, together with address bit zero, sets the access shape. There are four shapes: even byte, odd byte moved down onto the low lane, high lane only, and full word. With both enables deasserted, no access takes place.

For reads, the block turns the array word into the lane pattern and produces a tri-state enable for each lane. These enables are combinational from the control pins, so a lane stops driving in the same cycle the read condition goes away. For writes, the block sees a write-enable pulse in the clock domain. It takes the lane shape when the pulse starts and the data on the last clock edge of the pulse. When the pulse ends, it sends the array a one-cycle write strobe, with per-byte enables and the data already steered into byte position.

Top module: `lane_steer`

## Requirements
- R1: Even-byte read. With ce_lo_n=0, ce_hi_n=1, a0=0, oe_n=0 and we_n=1, lane_oe_lo=1, lane_oe_hi=0 and host_dq_out[7:0] equals arr_rdata[7:0].
- R2: Odd-byte read. With ce_lo_n=0, ce_hi_n=1, a0=1, oe_n=0 and we_n=1, lane_oe_lo=1, lane_oe_hi=0 and host_dq_out[7:0] equals arr_rdata[15:8].
- R3: High-lane read. With ce_lo_n=1, ce_hi_n=0, oe_n=0 and we_n=1, lane_oe_hi=1, lane_oe_lo=0 and host_dq_out[15:8] equals arr_rdata[15:8], for either value of a0.
- R4: Word read. With both enables low, oe_n=0 and we_n=1, both lane enables are 1 and host_dq_out equals arr_rdata, for either value of a0.
- R5: While oe_n=1, lane_oe_lo, lane_oe_hi and arr_rd are all 0, whatever the card enables are.
- R6: While ce_lo_n=1 and ce_hi_n=1, both lane enables and arr_rd are 0 and no write strobe is started, whatever oe_n and we_n are.
- R7: arr_rd equals lane_oe_lo OR lane_oe_hi, with no clock delay. No lane drives while we_n=0.
- R8: A write pulse is we_n low with oe_n high and at least one card enable low, seen on one or more rising clock edges. On the edge that first sees the pulse end, arr_wr rises, and it stays high for exactly one cycle. The lane shape comes from the pulse's first edge, and the data comes from the last edge of the pulse.
- R9: Write steering. An even byte gives arr_wbe=01 and arr_wdata[7:0]=dq[7:0]. An odd byte gives arr_wbe=10 and arr_wdata[15:8]=dq[7:0]. High lane only gives arr_wbe=10 and arr_wdata[15:8]=dq[15:8]. A word gives arr_wbe=11 and arr_wdata=dq. A byte that is not written reads 0, and arr_wbe and arr_wdata are 0 whenever arr_wr is 0.
- R10: we_n low while oe_n is low produces no write strobe and no lane drive.
- R11: During and right after reset, arr_wr, arr_wbe and arr_wdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write capture |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_lo_n | input | 1 | Active-low enable of the low data lane |
| ce_hi_n | input | 1 | Active-low enable of the high data lane |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| a0 | input | 1 | Address bit zero, selects the odd byte in byte access |
| host_dq_in | input | 16 | Data presented by the host on both lanes |
| host_dq_out | output | 16 | Read data steered onto the lanes |
| lane_oe_lo | output | 1 | Drive enable for lane bits 7:0 |
| lane_oe_hi | output | 1 | Drive enable for lane bits 15:8 |
| arr_rdata | input | 16 | Word read from the array |
| arr_rd | output | 1 | Array read strobe |
| arr_wr | output | 1 | One-cycle array write strobe |
| arr_wbe | output | 2 | Per-byte write enables, bit 1 is the high byte |
| arr_wdata | output | 16 | Write data placed in byte position |

## Verification
The hardest case to reach is a write pulse in which the data changes while we_n is still low. The write must commit the last value sampled, not the first, and the strobe must come one edge after the release. To reach this case, the directed write task changes host_dq_in partway through the low phase. It puts junk data on the bus in the same cycle it raises we_n, so committing the first sample or the post-release value would both show up as mismatches. Random reads vary the enable pattern and a0. Random writes of differing lengths sweep all four lane shapes.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

  typedef enum logic [2:0] {
    ACC_NONE = 3'd0,
    ACC_EVEN = 3'd1,
    ACC_ODD  = 3'd2,
    ACC_HIGH = 3'd3,
    ACC_WORD = 3'd4
  } acc_e;

  // Access shape from the enable pattern and address bit zero.
  function automatic acc_e decode_acc(input logic ce_lo_n, input logic ce_hi_n,
                                      input logic a0);
    acc_e r;
    case ({ce_lo_n, ce_hi_n})
      2'b00:   r = ACC_WORD;
      2'b01:   r = a0 ? ACC_ODD : ACC_EVEN;
      2'b10:   r = ACC_HIGH;
      default: r = ACC_NONE;
    endcase
    return r;
  endfunction

  // Byte write mask, bit 0 is the low byte.
  function automatic logic [1:0] acc_mask(input acc_e acc);
    logic [1:0] m;
    case (acc)
      ACC_EVEN: m = 2'b01;
      ACC_ODD:  m = 2'b10;
      ACC_HIGH: m = 2'b10;
      ACC_WORD: m = 2'b11;
      default:  m = 2'b00;
    endcase
    return m;
  endfunction

  // True when the host data for the high byte arrives on the low lane.
  function automatic logic acc_swapped(input acc_e acc);
    return acc == ACC_ODD;
  endfunction

endpackage

// File: rtl/lane_steer_decode.sv
module lane_steer_decode
  import lane_steer_pkg::*;
(
  input  logic ce_lo_n,
  input  logic ce_hi_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic a0,
  output acc_e acc,
  output logic rd_lo,
  output logic rd_hi,
  output logic wr_cond
);
  logic any_ce;
  logic rd_ok;

  always_comb begin
    acc     = decode_acc(ce_lo_n, ce_hi_n, a0);
    any_ce  = !ce_lo_n || !ce_hi_n;
    rd_ok   = !oe_n && we_n;
    rd_lo   = rd_ok && !ce_lo_n;
    rd_hi   = rd_ok && !ce_hi_n;
    wr_cond = any_ce && !we_n && oe_n;
  end
endmodule

// File: rtl/lane_steer_rdpath.sv
module lane_steer_rdpath
  import lane_steer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  acc_e              acc,
  input  logic [WORD_W-1:0] arr_rdata,
  output logic [WORD_W-1:0] dq_out
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    if (g == 0) begin : g_lo
      // Low lane carries the high byte for an odd-byte access.
      assign dq_out[BYTE_W-1:0] = acc_swapped(acc) ? arr_rdata[WORD_W-1:BYTE_W]
                                                   : arr_rdata[BYTE_W-1:0];
    end else begin : g_hi
      assign dq_out[WORD_W-1:BYTE_W] = arr_rdata[WORD_W-1:BYTE_W];
    end
  end
endmodule

// File: rtl/lane_steer_wrcap.sv
module lane_steer_wrcap
  import lane_steer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cond,
  input  acc_e              acc,
  input  logic [WORD_W-1:0] dq_in,
  output logic              wr_start,
  output logic              wr_end,
  output logic              arr_wr,
  output logic [1:0]        arr_wbe,
  output logic [WORD_W-1:0] arr_wdata
);
  logic              act_q;
  acc_e              acc_q;
  logic [WORD_W-1:0] raw_q;
  logic [WORD_W-1:0] steer_d;
  logic [1:0]        mask_d;

  assign wr_start = wr_cond && !act_q;
  assign wr_end   = act_q && !wr_cond;

  always_comb begin
    mask_d  = acc_mask(acc_q);
    steer_d = '0;
    case (acc_q)
      ACC_EVEN: steer_d[BYTE_W-1:0]      = raw_q[BYTE_W-1:0];
      ACC_ODD:  steer_d[WORD_W-1:BYTE_W] = raw_q[BYTE_W-1:0];
      ACC_HIGH: steer_d[WORD_W-1:BYTE_W] = raw_q[WORD_W-1:BYTE_W];
      ACC_WORD: steer_d                  = raw_q;
      default:  steer_d                  = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      acc_q     <= ACC_NONE;
      raw_q     <= '0;
      arr_wr    <= 1'b0;
      arr_wbe   <= '0;
      arr_wdata <= '0;
    end else begin
      act_q  <= wr_cond;
      if (wr_start) acc_q <= acc;
      if (wr_cond)  raw_q <= dq_in;
      arr_wr    <= wr_end;
      arr_wbe   <= wr_end ? mask_d  : 2'b00;
      arr_wdata <= wr_end ? steer_d : '0;
    end
  end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import lane_steer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_lo_n,
  input  logic              ce_hi_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              a0,
  input  logic [WORD_W-1:0] host_dq_in,
  output logic [WORD_W-1:0] host_dq_out,
  output logic              lane_oe_lo,
  output logic              lane_oe_hi,
  input  logic [WORD_W-1:0] arr_rdata,
  output logic              arr_rd,
  output logic              arr_wr,
  output logic [1:0]        arr_wbe,
  output logic [WORD_W-1:0] arr_wdata
);
  acc_e acc;
  logic rd_lo, rd_hi, wr_cond, wr_start, wr_end;

  lane_steer_decode u_dec (
    .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .oe_n(oe_n), .we_n(we_n), .a0(a0),
    .acc(acc), .rd_lo(rd_lo), .rd_hi(rd_hi), .wr_cond(wr_cond)
  );

  lane_steer_rdpath #(.BYTE_W(BYTE_W)) u_rd (
    .acc(acc), .arr_rdata(arr_rdata), .dq_out(host_dq_out)
  );

  lane_steer_wrcap #(.BYTE_W(BYTE_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_cond(wr_cond), .acc(acc), .dq_in(host_dq_in),
    .wr_start(wr_start), .wr_end(wr_end), .arr_wr(arr_wr), .arr_wbe(arr_wbe),
    .arr_wdata(arr_wdata)
  );

  assign lane_oe_lo = rd_lo;
  assign lane_oe_hi = rd_hi;
  assign arr_rd     = rd_lo || rd_hi;
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_lo_n,
  input logic              ce_hi_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              a0,
  input logic [WORD_W-1:0] host_dq_out,
  input logic              lane_oe_lo,
  input logic              lane_oe_hi,
  input logic [WORD_W-1:0] arr_rdata,
  input logic              arr_rd,
  input logic              arr_wr,
  input logic [1:0]        arr_wbe,
  input logic [WORD_W-1:0] arr_wdata,
  input logic              wr_cond
);
  a_r2_odd_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe_lo && ce_hi_n && a0) |->
      host_dq_out[BYTE_W-1:0] == arr_rdata[WORD_W-1:BYTE_W]);
  a_r3_low_lane_off: assert property (@(posedge clk) disable iff (!rst_n)
    ce_lo_n |-> !lane_oe_lo);
  a_r5_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!lane_oe_lo && !lane_oe_hi && !arr_rd));
  a_r6_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_lo_n && ce_hi_n) |-> (!lane_oe_lo && !lane_oe_hi && !arr_rd && !wr_cond));
  a_r7_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!lane_oe_lo && !lane_oe_hi));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |=> !arr_wr);
  a_r8_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |-> (!$past(wr_cond) && $past(wr_cond, 2)));
  a_r9_mask_present: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |-> (arr_wbe != 2'b00));
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_wr |-> (arr_wbe == 2'b00 && arr_wdata == '0));
  a_r10_oe_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !wr_cond);
endmodule

bind lane_steer lane_steer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .oe_n(oe_n),
  .we_n(we_n), .a0(a0), .host_dq_out(host_dq_out), .lane_oe_lo(lane_oe_lo),
  .lane_oe_hi(lane_oe_hi), .arr_rdata(arr_rdata), .arr_rd(arr_rd), .arr_wr(arr_wr),
  .arr_wbe(arr_wbe), .arr_wdata(arr_wdata), .wr_cond(wr_cond)
);

// File: tb/lane_steer_test.sv
module lane_steer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_lo_n = 1'b1, ce_hi_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, a0 = 1'b0;
  logic [15:0] host_dq_in = '0, arr_rdata = '0;
  logic [15:0] host_dq_out, arr_wdata;
  logic        lane_oe_lo, lane_oe_hi, arr_rd, arr_wr;
  logic [1:0]  arr_wbe;
  int          total = 0, bad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  lane_steer uut (
    .clk(clk), .rst_n(rst_n), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .oe_n(oe_n),
    .we_n(we_n), .a0(a0), .host_dq_in(host_dq_in), .host_dq_out(host_dq_out),
    .lane_oe_lo(lane_oe_lo), .lane_oe_hi(lane_oe_hi), .arr_rdata(arr_rdata),
    .arr_rd(arr_rd), .arr_wr(arr_wr), .arr_wbe(arr_wbe), .arr_wdata(arr_wdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected lane enables: {lo, hi}
  function automatic logic [1:0] exp_lanes(logic cl, logic ch, logic oe, logic we);
    logic rd;
    rd = !oe && we;
    return {rd && !cl, rd && !ch};
  endfunction

  // Expected low-lane read data
  function automatic logic [7:0] exp_lo_byte(logic a, logic ch, logic [15:0] w);
    if (ch && a) return w[15:8];
    return w[7:0];
  endfunction

  // Expected {wbe, wdata} of a write
  function automatic logic [17:0] exp_write(logic cl, logic ch, logic a, logic [15:0] d);
    if (!cl && !ch) return {2'b11, d};
    if (!cl && a)   return {2'b10, d[7:0], 8'h00};
    if (!cl)        return {2'b01, 8'h00, d[7:0]};
    if (!ch)        return {2'b10, d[15:8], 8'h00};
    return 18'h0;
  endfunction

  task automatic do_read(input logic cl, input logic ch, input logic oe,
                         input logic a, input logic [15:0] w, input string tag);
    logic [1:0] el;
    @(negedge clk);
    ce_lo_n = cl; ce_hi_n = ch; oe_n = oe; we_n = 1'b1; a0 = a; arr_rdata = w;
    #1;
    el = exp_lanes(cl, ch, oe, 1'b1);
    check({lane_oe_lo, lane_oe_hi} == el, {tag, " lanes"}, {lane_oe_lo, lane_oe_hi}, el);
    check(arr_rd == (el != 0), "R7 rd strobe", arr_rd, el != 0);
    if (el[1]) check(host_dq_out[7:0] == exp_lo_byte(a, ch, w), {tag, " lo data"},
                     host_dq_out[7:0], exp_lo_byte(a, ch, w));
    if (el[0]) check(host_dq_out[15:8] == w[15:8], {tag, " hi data"},
                     host_dq_out[15:8], w[15:8]);
  endtask

  task automatic do_write(input logic cl, input logic ch, input logic a,
                          input logic [15:0] d0, input logic [15:0] d1, input int extra);
    logic [17:0] e;
    @(negedge clk);
    ce_lo_n = cl; ce_hi_n = ch; oe_n = 1'b1; we_n = 1'b0; a0 = a; host_dq_in = d0;
    #1;
    check(!lane_oe_lo && !lane_oe_hi, "R7 no drive in write", {lane_oe_lo, lane_oe_hi}, 0);
    for (int i = 0; i < extra; i++) @(negedge clk);
    @(negedge clk);
    host_dq_in = d1;
    a0 = ~a;  // shape is taken at the pulse start
    @(negedge clk);
    we_n = 1'b1; host_dq_in = ~d1;
    #1;
    check(arr_wr == 1'b0, "R8 no strobe before release", arr_wr, 0);
    @(negedge clk);
    #1;
    e = exp_write(cl, ch, a, d1);
    check(arr_wr == 1'b1, "R8 strobe after release", arr_wr, 1);
    check(arr_wbe == e[17:16], "R9 wbe", arr_wbe, e[17:16]);
    check(arr_wdata == e[15:0], "R9 wdata", arr_wdata, e[15:0]);
    ce_lo_n = 1'b1; ce_hi_n = 1'b1;
    @(negedge clk);
    #1;
    check(arr_wr == 1'b0, "R8 single cycle", arr_wr, 0);
    check(arr_wbe == 2'b00 && arr_wdata == 16'h0, "R9 idle zero", {arr_wbe, arr_wdata}, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(arr_wr == 0 && arr_wbe == 0 && arr_wdata == 0, "R11 reset state",
          {arr_wr, arr_wbe, arr_wdata}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(arr_wr == 0, "R11 after reset", arr_wr, 0);

    // directed reads
    do_read(0, 1, 0, 0, 16'hA55A, "R1 even");
    do_read(0, 1, 0, 1, 16'hC33C, "R2 odd");
    do_read(1, 0, 0, 0, 16'h1234, "R3 high a0=0");
    do_read(1, 0, 0, 1, 16'h5678, "R3 high a0=1");
    do_read(0, 0, 0, 0, 16'h9ABC, "R4 word a0=0");
    do_read(0, 0, 0, 1, 16'hDEF0, "R4 word a0=1");
    do_read(0, 0, 1, 0, 16'hFFFF, "R5 oe high");
    do_read(1, 1, 0, 0, 16'hFFFF, "R6 standby");

    // same-cycle release of a read
    @(negedge clk); oe_n = 1'b1; #1;
    check(!lane_oe_lo && !lane_oe_hi, "R7 immediate release", {lane_oe_lo, lane_oe_hi}, 0);

    // directed writes, all shapes
    do_write(0, 1, 0, 16'h1111, 16'h00AB, 0);
    do_write(0, 1, 1, 16'h2222, 16'h00CD, 1);
    do_write(1, 0, 0, 16'h3333, 16'hEF00, 2);
    do_write(0, 0, 1, 16'h4444, 16'h7766, 0);

    // write enable with output enable low: ignored
    @(negedge clk);
    ce_lo_n = 0; ce_hi_n = 0; oe_n = 0; we_n = 0; host_dq_in = 16'hBEEF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check(arr_wr == 0 && !lane_oe_lo && !lane_oe_hi, "R10 oe low write",
            {arr_wr, lane_oe_lo, lane_oe_hi}, 0);
    end
    we_n = 1'b1; oe_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); #1;
      check(arr_wr == 0, "R10 no strobe after", arr_wr, 0);
    end

    // standby write attempt
    @(negedge clk);
    ce_lo_n = 1; ce_hi_n = 1; we_n = 0;
    @(negedge clk); we_n = 1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); #1;
      check(arr_wr == 0, "R6 standby no write", arr_wr, 0);
    end

    // random reads
    for (int i = 0; i < 300; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      do_read(r[0], r[1], r[2], r[3], 16'($urandom), "R1 R2 R3 R4 R5 random");
    end

    // random writes
    for (int i = 0; i < 40; i++) begin
      logic [2:0] r;
      r = 3'($urandom);
      if (r[1:0] == 2'b11) r[1] = 1'b0;
      do_write(r[0], r[1], r[2], 16'($urandom), 16'($urandom), int'($urandom % 3));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule